// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block takes one maintenance command at a time from software and turns it into a series of per-line requests to the line-state array of a write-back cache. There are three kinds of work: cleaning dirty lines while keeping them valid, flushing dirty lines and then invalidating them, and invalidating lines while throwing away any dirty data. Cleaning and flushing can each be aimed at the whole cache. All three can be aimed at a byte range.

For a whole-cache command the sequencer walks the line index from zero up to the last line. For a range command it walks line addresses upward, one line at a time, from the line that holds the first byte to the line that holds the last byte. Each request stays on the request port until the line-state model acknowledges it. The data array and the memory transfer sit behind that model.

Top module: `cmo_sequencer`

## Requirements
- R1: After reset `cmd_ready` is 1, and `busy`, `done`, `req_valid` and `misaligned` are all 0.
- R2: Command code 1 (clean all) and code 2 (flush+invalidate all) issue one request for each line index 0 to NUM_LINES-1, in ascending order. Each request has `req_addr` = index*LINE_BYTES. The action is 2'b01 for code 1 and 2'b10 for code 2.
- R3: Range codes are 3 (clean range, action 2'b01), 4 (flush+invalidate range, action 2'b10) and 5 (discard range, action 2'b11). Each issues requests for the line addresses from floor(start/LINE_BYTES) to floor((start+size-1)/LINE_BYTES), ascending, and for no other line.
- R4: A request keeps the same `req_addr` and `req_action` until `req_ack` is sampled high. Each acknowledge moves the walk forward by exactly one line.
- R5: A range command whose start or size has a nonzero value in bits [5:0] (for LINE_BYTES=64) sets `misaligned`. The span is still rounded outward to whole lines. The flag stays set until reset, and every `req_addr` has zero in those bits.
- R6: A range command with size 0 raises `done` in the cycle right after acceptance and issues no request.
- R7: A command is accepted at a clock edge where `cmd_valid` and `cmd_ready` are both high. `busy` is high from the next cycle up to and including the single cycle in which `done` is high. `cmd_ready` is high only while idle.
- R8: A command presented while `busy` is high is not accepted and causes no request.
- R9: Command codes 0, 6 and 7 complete with a `done` one cycle after acceptance. They issue no request and leave `misaligned` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| cmd_start | input | AW | Range start byte address |
| cmd_size | input | AW | Range size in bytes |
| cmd_ready | output | 1 | Idle and able to accept a command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| misaligned | output | 1 | Sticky flag for an unaligned range |
| req_valid | output | 1 | Per-line request present |
| req_addr | output | AW | Line address, or line index times line size |
| req_action | output | 2 | 01 clean, 10 flush+invalidate, 11 discard |
| req_ack | input | 1 | Line-state model accepted the request |

## Verification
A corrupted walk counter or end bound shows up at the request port at the next acknowledge: a skipped, repeated or extra line address that the per-command expected list does not contain. A wrong latched action shows up on the first request of a command, in the cycle after acceptance. A control state that is stuck or leaves early shows up as a missing or early `done` pulse, or as `cmd_ready` coming back while lines are still outstanding. A lost or spurious alignment flag is visible on `misaligned` one cycle after the command is accepted.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_CLN_ALL = 3'd1,
      OP_FLI_ALL = 3'd2,
      OP_CLN_RNG = 3'd3,
      OP_FLI_RNG = 3'd4,
      OP_DSC_RNG = 3'd5
   } cmo_op_e;

   typedef enum logic [1:0] {
      ACT_NONE    = 2'b00,
      ACT_CLEAN   = 2'b01,
      ACT_FLU_INV = 2'b10,
      ACT_DISCARD = 2'b11
   } line_act_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_RUN,
      SQ_FIN
   } sq_state_e;

   typedef struct packed {
      line_act_e act;
      logic      whole;
      logic      ranged;
   } op_info_t;
endpackage

// File: rtl/cmo_decode.sv
module cmo_decode
   import cmo_pkg::*;
(
   input  logic [2:0] op,
   output op_info_t   info
);
   always_comb begin
      info = '{act: ACT_NONE, whole: 1'b0, ranged: 1'b0};
      case (op)
         OP_CLN_ALL: info = '{act: ACT_CLEAN,   whole: 1'b1, ranged: 1'b0};
         OP_FLI_ALL: info = '{act: ACT_FLU_INV, whole: 1'b1, ranged: 1'b0};
         OP_CLN_RNG: info = '{act: ACT_CLEAN,   whole: 1'b0, ranged: 1'b1};
         OP_FLI_RNG: info = '{act: ACT_FLU_INV, whole: 1'b0, ranged: 1'b1};
         OP_DSC_RNG: info = '{act: ACT_DISCARD, whole: 1'b0, ranged: 1'b1};
         default:    info = '{act: ACT_NONE,    whole: 1'b0, ranged: 1'b0};
      endcase
   end
endmodule

// File: rtl/cmo_span_calc.sv
module cmo_span_calc #(
   parameter int AW         = 16,
   parameter int LINE_BYTES = 64
) (
   input  logic [AW-1:0]                   start,
   input  logic [AW-1:0]                   size,
   output logic [AW-$clog2(LINE_BYTES)-1:0] first_line,
   output logic [AW-$clog2(LINE_BYTES)-1:0] last_line,
   output logic                            empty,
   output logic                            unaligned
);
   localparam int OFS = $clog2(LINE_BYTES);
   localparam int LW  = AW - OFS;

   assign first_line = start[AW-1:OFS];
   assign last_line  = LW'((start + size - 1'b1) >> OFS);
   assign empty      = (size == '0);

   generate
      if (OFS > 0) begin : g_chk
         assign unaligned = |{start[OFS-1:0], size[OFS-1:0]};
      end else begin : g_nochk
         assign unaligned = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cmo_walker.sv
module cmo_walker #(
   parameter int LW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [LW-1:0] load_first,
   input  logic [LW-1:0] load_last,
   input  logic          step,
   output logic [LW-1:0] cur_line,
   output logic          at_last
);
   logic [LW-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_line <= '0;
         last_q   <= '0;
      end else if (load) begin
         cur_line <= load_first;
         last_q   <= load_last;
      end else if (step) begin
         cur_line <= cur_line + 1'b1;
      end
   end

   assign at_last = (cur_line == last_q);
endmodule

// File: rtl/cmo_sequencer.sv
module cmo_sequencer
   import cmo_pkg::*;
#(
   parameter int AW         = 16,
   parameter int LINE_BYTES = 64,
   parameter int NUM_LINES  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_op,
   input  logic [AW-1:0] cmd_start,
   input  logic [AW-1:0] cmd_size,
   output logic          cmd_ready,
   output logic          busy,
   output logic          done,
   output logic          misaligned,
   output logic          req_valid,
   output logic [AW-1:0] req_addr,
   output logic [1:0]    req_action,
   input  logic          req_ack
);
   localparam int OFS = $clog2(LINE_BYTES);
   localparam int LW  = AW - OFS;

   generate
      if (LINE_BYTES != (1 << OFS)) begin : g_bad_line
         $error("LINE_BYTES must be a power of two");
      end
      if (NUM_LINES < 1 || NUM_LINES > (1 << LW)) begin : g_bad_lines
         $error("NUM_LINES must fit the line address width");
      end
   endgenerate

   sq_state_e     state_q, state_d;
   line_act_e     act_q;
   logic          mis_q;
   op_info_t      info;
   logic [LW-1:0] span_first, span_last, cur_line;
   logic          span_empty, span_unal, at_last;
   logic          accept, step, finish_now;

   cmo_decode u_decode (.op(cmd_op), .info(info));

   cmo_span_calc #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_span (
      .start(cmd_start), .size(cmd_size),
      .first_line(span_first), .last_line(span_last),
      .empty(span_empty), .unaligned(span_unal)
   );

   assign accept     = cmd_valid && (state_q == SQ_IDLE);
   assign step       = (state_q == SQ_RUN) && req_ack && !at_last;
   assign finish_now = (info.act == ACT_NONE) || (info.ranged && span_empty);

   cmo_walker #(.LW(LW)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .load_first(info.whole ? '0 : span_first),
      .load_last(info.whole ? LW'(NUM_LINES - 1) : span_last),
      .step(step), .cur_line(cur_line), .at_last(at_last)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         SQ_IDLE: if (accept) state_d = finish_now ? SQ_FIN : SQ_RUN;
         SQ_RUN:  if (req_ack && at_last) state_d = SQ_FIN;
         SQ_FIN:  state_d = SQ_IDLE;
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         act_q   <= ACT_NONE;
         mis_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            act_q <= info.act;
            if (info.ranged && span_unal) mis_q <= 1'b1;
         end
      end
   end

   assign cmd_ready  = (state_q == SQ_IDLE);
   assign busy       = (state_q != SQ_IDLE);
   assign done       = (state_q == SQ_FIN);
   assign misaligned = mis_q;
   assign req_valid  = (state_q == SQ_RUN);
   assign req_addr   = AW'(cur_line) << OFS;
   assign req_action = req_valid ? act_q : ACT_NONE;
endmodule

// File: rtl/cmo_sequencer_chk.sv
module cmo_sequencer_chk #(
   parameter int AW         = 16,
   parameter int LINE_BYTES = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic          busy,
   input logic          done,
   input logic          misaligned,
   input logic          req_valid,
   input logic [AW-1:0] req_addr,
   input logic [1:0]    req_action,
   input logic          req_ack
);
   localparam logic [AW-1:0] MASK = AW'(LINE_BYTES - 1);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_action)); // R4
   AST_REQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ack |=> !req_valid || (req_addr == $past(req_addr) + AW'(LINE_BYTES))); // R3
   AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr & MASK) == '0); // R5
   AST_REQ_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_action != 2'b00); // R2
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      misaligned |=> misaligned); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !busy && !req_valid); // R7
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> busy); // R7
endmodule

bind cmo_sequencer cmo_sequencer_chk #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_chk (.*);

// File: tb/cmo_sequencer_bench.sv
module cmo_sequencer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int LB = 64;
   localparam int NL = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = '0;
   logic [AW-1:0] cmd_start = '0, cmd_size = '0;
   logic          cmd_ready, busy, done, misaligned, req_valid;
   logic [AW-1:0] req_addr;
   logic [1:0]    req_action;
   logic          req_ack = 1'b0;

   int compared = 0;
   int mismatched = 0;
   int ack_cnt = 0;
   string cur_tag = "R1";
   logic [AW+1:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cmo_sequencer #(.AW(AW), .LINE_BYTES(LB), .NUM_LINES(NL)) u_cmo_sequencer (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_start(cmd_start), .cmd_size(cmd_size), .cmd_ready(cmd_ready),
      .busy(busy), .done(done), .misaligned(misaligned), .req_valid(req_valid),
      .req_addr(req_addr), .req_action(req_action), .req_ack(req_ack)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   // monitor and responder
   initial begin
      forever begin
         @(negedge clk);
         req_ack = 1'b0;
         if (rst_n && req_valid) begin
            repeat (ack_cnt % 3) @(negedge clk);
            ack_cnt++;
            if (exp_q.size() == 0) begin
               chk(1'b0, cur_tag, "unexpected request", {14'd0, req_addr, req_action}, 32'd0);
            end else begin
               logic [AW+1:0] e;
               e = exp_q.pop_front();
               chk({req_addr, req_action} == e, cur_tag, "request addr/action",
                   {14'd0, req_addr, req_action}, {14'd0, e});
            end
            req_ack = 1'b1;
         end
      end
   end

   task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] st,
                          input logic [AW-1:0] sz, input string tag,
                          input bit hold_busy, input bit immediate);
      int cycles;
      cur_tag = tag;
      if (op == 3'd1 || op == 3'd2) begin
         for (int i = 0; i < NL; i++)
            exp_q.push_back({AW'(i * LB), (op == 3'd1) ? 2'b01 : 2'b10});
      end else if (op >= 3'd3 && op <= 3'd5 && sz != 0) begin
         int first, last;
         first = int'(st) / LB;
         last  = (int'(st) + int'(sz) - 1) / LB;
         for (int l = first; l <= last; l++)
            exp_q.push_back({AW'(l * LB), (op == 3'd3) ? 2'b01 : (op == 3'd4) ? 2'b10 : 2'b11});
      end
      @(negedge clk);
      cmd_op = op; cmd_start = st; cmd_size = sz; cmd_valid = 1'b1;
      @(negedge clk);
      if (hold_busy) begin
         cmd_op = 3'd5; cmd_start = 16'h2000; cmd_size = 16'h0040;
      end else begin
         cmd_valid = 1'b0;
      end
      cycles = 0;
      while (!done) begin
         if (hold_busy) chk(cmd_ready == 1'b0, "R8", "ready while busy", cmd_ready, 0);
         @(negedge clk);
         cycles++;
      end
      cmd_valid = 1'b0;
      if (immediate) chk(cycles == 0, tag, "cycles to done", cycles, 0);
      chk(busy == 1'b1, "R7", "busy during done", busy, 1);
      chk(exp_q.size() == 0, tag, "lines left at done", exp_q.size(), 0);
      @(negedge clk);
      chk(!done && !busy && cmd_ready, "R7", "idle after done",
          {done, busy, cmd_ready}, 3'b001);
      exp_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
      chk({busy, done, req_valid, misaligned} == 4'b0, "R1", "idle outputs",
          {busy, done, req_valid, misaligned}, 0);
      rst_n = 1'b1;
      run_cmd(3'd1, 16'h0000, 16'h0000, "R2", 1'b0, 1'b0);
      run_cmd(3'd2, 16'h0000, 16'h0000, "R2", 1'b0, 1'b0);
      run_cmd(3'd3, 16'h0100, 16'h00C0, "R3", 1'b0, 1'b0);
      run_cmd(3'd4, 16'h0400, 16'h0040, "R3", 1'b0, 1'b0);
      run_cmd(3'd5, 16'h1000, 16'h0100, "R4", 1'b0, 1'b0);
      chk(misaligned == 1'b0, "R5", "flag after aligned", misaligned, 0);
      run_cmd(3'd3, 16'h0200, 16'h0000, "R6", 1'b0, 1'b1);
      run_cmd(3'd6, 16'h0013, 16'h0040, "R9", 1'b0, 1'b1);
      run_cmd(3'd0, 16'h0000, 16'h0040, "R9", 1'b0, 1'b1);
      chk(misaligned == 1'b0, "R9", "flag after no-op", misaligned, 0);
      run_cmd(3'd1, 16'h0000, 16'h0000, "R8", 1'b1, 1'b0);
      chk(req_valid == 1'b0, "R8", "held command not accepted", req_valid, 0);
      run_cmd(3'd4, 16'h0050, 16'h0080, "R5", 1'b0, 1'b0);
      chk(misaligned == 1'b1, "R5", "flag after unaligned", misaligned, 1);
      run_cmd(3'd5, 16'h0800, 16'h0080, "R5", 1'b0, 1'b0);
      chk(misaligned == 1'b1, "R5", "flag sticky", misaligned, 1);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      compared++;
      $display("FAIL watchdog %s: actual hung expected done", cur_tag);
      finish_run();
   end
endmodule